// File: doc/BRIEF.md
# Byte-FIFO I2C Bus Master

This block is the only master on a two-wire I2C bus. Software talks to it through a small register port. It writes a target address with a direction bit and a byte count. For a write it queues outgoing bytes in a four-entry transmit FIFO, and for a read it collects incoming bytes from a four-entry receive FIFO. The block runs each frame by itself. It issues START, sends the address byte, checks every acknowledge, moves the data bytes and closes the bus with STOP. On reads it acknowledges each incoming byte itself and sends a NACK on the last one.

A transfer ends when the byte count is reached, when the target does not acknowledge, or when the transmit FIFO runs dry while another byte is still owed. A sticky status bit records which of these ended it. If software writes a new address while a transfer is in flight, the block follows the current operation with a repeated START to the new target instead of releasing the bus. Both bus lines are modelled as open-drain pins: an output-enable pulls the line low and a separate input reads the wired level. SCL is generated from a programmable divider. The block does not arbitrate between masters, does not follow clock stretching by a target and has no slave mode.

Register map (3-bit `reg_addr`): 0 = command (write `{addr7, dir}`, dir 1 = read), 1 = byte count `[4:0]`, 2 = TX push, 3 = RX pop (read), 4 = control (bit0 TX interrupt enable, bit1 RX interrupt enable, bit2 RX mode: 0 = per byte, 1 = FIFO full), 5 = status, 6 = divider. Status bits: 0 busy, 1 TX flag, 2 RX flag, 3 done, 4 NACK error, 5 TX underrun, 6 TX overflow, 7 RX underflow. Bits 3 to 7 are sticky, and writing 1 to a bit clears it.

Top module: `i2cm_top`

## Requirements
- R1: Each FIFO holds four bytes. A push to register 2 while the TX FIFO is full is dropped and sets status bit 6. A read of register 3 while the RX FIFO is empty removes nothing and sets status bit 7. Writing 1 to either bit in register 5 clears it.
- R2: A frame begins with START. The address byte follows, seven address bits MSB first and then the direction bit (1 = read). The target's acknowledge is sampled on the ninth SCL pulse, and data bytes are also sent MSB first.
- R3: A write with count N sends N bytes from the TX FIFO in push order, each one acknowledged, then STOP, and sets status bit 3.
- R4: A read with count N stores N bytes in the RX FIFO in arrival order. The master drives ACK (SDA low) after every byte except the last and a NACK after the last, then STOP, and sets status bit 3.
- R5: A missing acknowledge on the address byte or on a data byte ends the transfer with STOP and sets status bit 4. If the transfer was a write, the TX FIFO is emptied.
- R6: If the TX FIFO is empty when the next write byte is needed, the transfer ends with STOP and sets status bit 5. Bytes already acknowledged stay delivered.
- R7: A command write while busy is held. When the current operation completes, the master issues a repeated START with the new address and direction, and no STOP in between.
- R8: The TX flag (status bit 1) is high whenever the TX FIFO is empty. The RX flag (status bit 2) is high when the RX FIFO is non-empty in mode 0 and when it is full in mode 1. `irq` is the OR of each flag gated by its enable.
- R9: One SCL period lasts 4*(DIV+1) clock cycles. SDA changes only while SCL is low, except at START and STOP, and it never changes in the cycle in which SCL falls.
- R10: After reset and whenever idle, both lines are released and status bit 0 is low. The reset status reads 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on address 3) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Wired SDA level |

## Verification
Flag and FIFO effects of a register access appear on the first rising edge after the strobe, so the bench reads them back at the next falling edge. Bus results arrive many cycles later. Each scenario therefore polls the busy bit until the block is idle, and only then compares what the bench's target model captured and the sticky status bits against values derived from the requirements. SCL period checks count clock cycles between consecutive SCL rising edges, with the expected value 4*(DIV+1) computed for each divider setting.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_WDAT, PH_RDAT} ph_t;
  typedef enum logic [1:0] {END_NONE, END_DONE, END_NACK, END_URUN} end_t;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_CNT  = 3'd1;
  localparam logic [2:0] RA_TX   = 3'd2;
  localparam logic [2:0] RA_RX   = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_DIV  = 3'd6;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [LW-1:0] lvl, lvl_n;
  logic          do_push, do_pop;

  assign empty   = (lvl == '0);
  assign full    = (lvl == FULL_LVL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    lvl_n = lvl;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (do_push) wp_n = (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp_n = (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop) lvl_n = lvl + 1'b1;
      else if (do_pop && !do_push) lvl_n = lvl - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      lvl <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt, cnt_n;

  assign tick = en && (cnt == '0);

  always_comb begin
    cnt_n = cnt;
    if (!en)       cnt_n = div;
    else if (tick) cnt_n = div;
    else           cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_byte,
  input  logic [CW-1:0] count,
  input  logic          tx_empty,
  input  logic [7:0]    tx_data,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [7:0]    rx_data,
  output logic          flush,
  output logic          busy,
  output logic          fin,
  output end_t          fin_code,
  output logic          scl_lo,
  output logic          sda_lo,
  input  logic          sda_in
);
  st_t           st, st_n;
  ph_t           ph, ph_n;
  end_t          term, term_n;
  logic [1:0]    q, q_n;
  logic [3:0]    bitn, bit_n;
  logic [7:0]    sh, sh_n, cur, cur_n, nxt, nxt_n;
  logic [CW-1:0] nbytes, nb_n;
  logic [CW:0]   nb_inc;
  logic          pend, pend_n, first, first_n, scl_n, sda_n;
  logic          last, ack, drv;
  logic          op_end, err_nack, err_urun, do_load;

  assign busy     = (st != ST_IDLE);
  assign fin_code = term;
  assign rx_data  = {sh[6:0], sda_in};
  assign nb_inc   = {1'b0, nbytes} + {{CW{1'b0}}, 1'b1};
  assign last     = (nb_inc == {1'b0, count});
  assign ack      = ~sda_in;

  always_comb begin
    if (bitn != 4'd8) drv = (ph == PH_RDAT) ? 1'b0 : ~sh[7];
    else              drv = (ph == PH_RDAT) ? ~last : 1'b0;
  end

  always_comb begin
    st_n = st; ph_n = ph; q_n = q; bit_n = bitn; sh_n = sh; nb_n = nbytes;
    cur_n = cur; nxt_n = nxt; pend_n = pend; first_n = first; term_n = term;
    scl_n = scl_lo; sda_n = sda_lo;
    tx_pop = 1'b0; rx_push = 1'b0; flush = 1'b0; fin = 1'b0;
    op_end = 1'b0; err_nack = 1'b0; err_urun = 1'b0; do_load = 1'b0;
    if (cmd_wr) begin
      nxt_n  = cmd_byte;
      pend_n = 1'b1;
    end
    unique case (st)
      ST_IDLE: begin
        scl_n = 1'b0;
        sda_n = 1'b0;
        if (pend) begin
          st_n = ST_START; q_n = 2'd0; first_n = 1'b1; cur_n = nxt; pend_n = cmd_wr;
        end
      end
      ST_START: if (tick) begin
        q_n = q + 2'd1;
        case (q)
          2'd0: begin scl_n = ~first; first_n = 1'b0; end
          2'd1: sda_n = 1'b0;
          2'd2: scl_n = 1'b0;
          default: begin
            sda_n = 1'b1; st_n = ST_BIT; ph_n = PH_ADDR;
            bit_n = 4'd0; sh_n = cur; nb_n = '0;
          end
        endcase
      end
      ST_BIT: if (tick) begin
        q_n = q + 2'd1;
        case (q)
          2'd0: scl_n = 1'b1;
          2'd1: sda_n = drv;
          2'd2: scl_n = 1'b0;
          default: begin
            if (bitn != 4'd8) begin
              sh_n  = {sh[6:0], sda_in};
              bit_n = bitn + 4'd1;
              if (bitn == 4'd7 && ph == PH_RDAT) rx_push = 1'b1;
            end else begin
              bit_n = 4'd0;
              unique case (ph)
                PH_ADDR: begin
                  if (!ack) err_nack = 1'b1;
                  else if (count == '0) op_end = 1'b1;
                  else if (cur[0]) ph_n = PH_RDAT;
                  else if (tx_empty) err_urun = 1'b1;
                  else do_load = 1'b1;
                end
                PH_WDAT: begin
                  nb_n = nb_inc[CW-1:0];
                  if (!ack) err_nack = 1'b1;
                  else if (last) op_end = 1'b1;
                  else if (tx_empty) err_urun = 1'b1;
                  else do_load = 1'b1;
                end
                default: begin
                  nb_n = nb_inc[CW-1:0];
                  if (last) op_end = 1'b1;
                end
              endcase
            end
          end
        endcase
      end
      ST_STOP: if (tick) begin
        q_n = q + 2'd1;
        case (q)
          2'd0: scl_n = 1'b1;
          2'd1: sda_n = 1'b1;
          2'd2: scl_n = 1'b0;
          default: begin sda_n = 1'b0; st_n = ST_IDLE; fin = 1'b1; end
        endcase
      end
      default: st_n = ST_IDLE;
    endcase

    if (do_load) begin
      sh_n = tx_data; tx_pop = 1'b1; ph_n = PH_WDAT;
    end
    if (op_end) begin
      if (pend) begin
        st_n = ST_START; q_n = 2'd0; cur_n = nxt; pend_n = cmd_wr;
      end else begin
        st_n = ST_STOP; term_n = END_DONE;
      end
    end
    if (err_nack) begin
      st_n = ST_STOP; term_n = END_NACK; pend_n = 1'b0; flush = ~cur[0];
    end
    if (err_urun) begin
      st_n = ST_STOP; term_n = END_URUN; pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR; term <= END_NONE; q <= '0; bitn <= '0;
      sh <= '0; cur <= '0; nxt <= '0; nbytes <= '0; pend <= 1'b0; first <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      st <= st_n; ph <= ph_n; term <= term_n; q <= q_n; bitn <= bit_n;
      sh <= sh_n; cur <= cur_n; nxt <= nxt_n; nbytes <= nb_n; pend <= pend_n;
      first <= first_n; scl_lo <= scl_n; sda_lo <= sda_n;
    end
  end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 5,
  parameter int DW    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] div_q, div_n;
  logic [2:0]    ctl_q, ctl_n;
  logic          done_f, nack_f, urun_f, ovf_f, udf_f;
  logic          done_n, nack_n, urun_n, ovf_n, udf_n;
  logic          tx_push, tx_pop, tx_empty, tx_full, flush;
  logic          rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]    tx_dout, rx_din, rx_dout, stat;
  logic          busy, tick, fin, cmd_wr, stat_wr, tx_flag, rx_flag;
  end_t          fin_code;

  assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
  assign tx_push = reg_wr && (reg_addr == RA_TX);
  assign stat_wr = reg_wr && (reg_addr == RA_STAT);
  assign rx_pop  = reg_rd && (reg_addr == RA_RX);

  i2cm_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .flush(flush),
    .din(reg_wdata), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  i2cm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .flush(1'b0),
    .din(rx_din), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  i2cm_tick #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .div(div_q), .tick(tick));

  i2cm_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_wr(cmd_wr), .cmd_byte(reg_wdata),
    .count(cnt_q), .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_din), .flush(flush), .busy(busy), .fin(fin),
    .fin_code(fin_code), .scl_lo(scl_oe), .sda_lo(sda_oe), .sda_in(sda_in));

  assign tx_flag = tx_empty;
  assign rx_flag = ctl_q[2] ? rx_full : !rx_empty;
  assign irq     = (ctl_q[0] && tx_flag) || (ctl_q[1] && rx_flag);
  assign stat    = {udf_f, ovf_f, urun_f, nack_f, done_f, rx_flag, tx_flag, busy};

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    ctl_n = ctl_q;
    if (reg_wr && reg_addr == RA_CNT)  cnt_n = reg_wdata[CW-1:0];
    if (reg_wr && reg_addr == RA_DIV)  div_n = reg_wdata[DW-1:0];
    if (reg_wr && reg_addr == RA_CTRL) ctl_n = reg_wdata[2:0];
    done_n = (done_f && !(stat_wr && reg_wdata[3])) || (fin && fin_code == END_DONE);
    nack_n = (nack_f && !(stat_wr && reg_wdata[4])) || (fin && fin_code == END_NACK);
    urun_n = (urun_f && !(stat_wr && reg_wdata[5])) || (fin && fin_code == END_URUN);
    ovf_n  = (ovf_f  && !(stat_wr && reg_wdata[6])) || (tx_push && tx_full);
    udf_n  = (udf_f  && !(stat_wr && reg_wdata[7])) || (rx_pop && rx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; div_q <= '1; ctl_q <= '0;
      done_f <= 1'b0; nack_f <= 1'b0; urun_f <= 1'b0; ovf_f <= 1'b0; udf_f <= 1'b0;
    end else begin
      cnt_q <= cnt_n; div_q <= div_n; ctl_q <= ctl_n;
      done_f <= done_n; nack_f <= nack_n; urun_f <= urun_n; ovf_f <= ovf_n; udf_f <= udf_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CNT:  reg_rdata = 8'(cnt_q);
      RA_RX:   reg_rdata = rx_dout;
      RA_CTRL: reg_rdata = {5'd0, ctl_q};
      RA_STAT: reg_rdata = stat;
      RA_DIV:  reg_rdata = 8'(div_q);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic fin,
  input logic tx_push,
  input logic tx_full,
  input logic rx_pop,
  input logic rx_empty,
  input logic udf_f
);
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_sda_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $stable(sda_oe));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !busy) |=> tx_full);

  p_rx_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> udf_f);

  p_stop_then_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy && !scl_oe && !sda_oe));
endmodule

bind i2cm_top i2cm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .fin(fin), .tx_push(tx_push), .tx_full(tx_full), .rx_pop(rx_pop),
  .rx_empty(rx_empty), .udf_f(udf_f));

// File: tb/tb_i2cm_top.sv
`timescale 1ns/1ps
module tb_i2cm_top;
  localparam logic [6:0] SLV = 7'h52;

  logic       clk, rst_n, reg_wr, reg_rd, irq, scl_oe, sda_oe;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       s_lo;
  wire        scl_bus = ~scl_oe;
  wire        sda_bus = ~(sda_oe | s_lo);

  int errors, checks, cyc, starts, stops, wn, ridx, nack_at, s_bit, per, prev_rise;
  logic [7:0] wmem [8];
  logic       macks [8];
  logic [7:0] s_sh, cur, addr_seen;
  logic       s_act, s_data, s_sel, s_rd, s_send, finished;

  i2cm_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_bus));

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [7:0] rd_val(int k);
    return 8'hC0 + 8'(k);
  endfunction

  // target model
  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    s_act = 1; s_data = 0; s_bit = 0; s_lo = 0; starts++;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1 && s_act) begin
    s_act = 0; s_lo = 0; stops++;
  end
  always @(posedge scl_bus) begin
    if (prev_rise >= 0) per = cyc - prev_rise;
    prev_rise = cyc;
    if (s_act) begin
      if (s_bit < 8) s_sh = {s_sh[6:0], sda_bus};
      else if (s_data && s_rd && s_sel) begin
        macks[ridx] = sda_bus; ridx++; s_send = !sda_bus;
      end
      s_bit++;
    end
  end
  always @(negedge scl_bus) if (s_act) begin
    if (s_bit == 8) begin
      if (!s_data) begin
        addr_seen = s_sh; s_sel = (s_sh[7:1] == SLV); s_rd = s_sh[0];
        s_lo = s_sel; s_send = s_sel && s_rd; ridx = 0;
      end else if (!s_rd && s_sel) begin
        wmem[wn] = s_sh; s_lo = (wn != nack_at); wn++;
      end else s_lo = 0;
    end else if (s_bit == 9) begin
      s_bit = 0; s_data = 1;
      if (s_rd && s_sel && s_send) begin cur = rd_val(ridx); s_lo = ~cur[7]; end
      else s_lo = 0;
    end else if (s_data && s_rd && s_sel && s_send && s_bit >= 1 && s_bit <= 7)
      s_lo = ~cur[7 - s_bit];
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clr_slave();
    wn = 0; starts = 0; stops = 0; nack_at = -1;
    wr(3'd5, 8'hF8);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rd(3'd5, s);
    chk("R10 reset status", s, 8'h02);
    chk("R10 reset lines", {scl_oe, sda_oe}, 0);
    chk("R8 reset irq", irq, 0);
  endtask

  task automatic t_write();
    logic [7:0] s;
    clr_slave();
    wr(3'd4, 8'h01); wr(3'd6, 8'd1); wr(3'd1, 8'd3);
    wr(3'd2, 8'h5A); wr(3'd2, 8'h81); wr(3'd2, 8'hFF);
    chk("R8 irq low with TX data", irq, 0);
    wr(3'd0, {SLV, 1'b0});
    wait_idle();
    chk("R2 address byte", addr_seen, {SLV, 1'b0});
    chk("R3 byte count", wn, 3);
    chk("R3 byte0", wmem[0], 8'h5A);
    chk("R3 byte1", wmem[1], 8'h81);
    chk("R3 byte2", wmem[2], 8'hFF);
    chk("R3 start/stop", starts * 16 + stops, 8'h11);
    rd(3'd5, s);
    chk("R3 done bit", s[5:3], 3'b001);
    chk("R8 tx irq when empty", irq, 1);
    wr(3'd5, 8'h08); rd(3'd5, s);
    chk("R3 done cleared", s[3], 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_read_full();
    logic [7:0] s, d;
    clr_slave();
    wr(3'd4, 8'h06); wr(3'd1, 8'd4);
    wr(3'd0, {SLV, 1'b1});
    wait_idle();
    rd(3'd5, s);
    chk("R4 done bit", s[5:3], 3'b001);
    chk("R8 rx flag full mode", s[2], 1);
    chk("R8 rx irq", irq, 1);
    chk("R4 master acks", {macks[0], macks[1], macks[2], macks[3]}, 4'b0001);
    chk("R4 stops", stops, 1);
    for (int k = 0; k < 4; k++) begin
      rd(3'd3, d);
      chk("R4 rx byte", d, rd_val(k));
    end
    chk("R8 irq drops after pops", irq, 0);
  endtask

  task automatic t_read_modes();
    logic [7:0] s, d;
    clr_slave();
    wr(3'd4, 8'h06); wr(3'd1, 8'd2);
    wr(3'd0, {SLV, 1'b1});
    wait_idle();
    rd(3'd5, s);
    chk("R8 full mode not full", {s[2], irq}, 0);
    chk("R4 two-byte acks", {macks[0], macks[1]}, 2'b01);
    wr(3'd4, 8'h02); rd(3'd5, s);
    chk("R8 per-byte mode flag", {s[2], irq}, 2'b11);
    rd(3'd3, d); chk("R4 first", d, 8'hC0);
    rd(3'd3, d); chk("R4 second", d, 8'hC1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_nack_addr();
    logic [7:0] s;
    clr_slave();
    wr(3'd1, 8'd2); wr(3'd2, 8'h11); wr(3'd2, 8'h22);
    wr(3'd0, {7'h13, 1'b0});
    wait_idle();
    rd(3'd5, s);
    chk("R5 addr nack status", s[5:3], 3'b010);
    chk("R5 tx flushed", s[1], 1);
    chk("R5 nothing written", wn, 0);
    chk("R5 stop issued", stops, 1);
  endtask

  task automatic t_nack_data();
    logic [7:0] s;
    clr_slave(); nack_at = 1;
    wr(3'd1, 8'd3); wr(3'd2, 8'h31); wr(3'd2, 8'h32); wr(3'd2, 8'h33);
    wr(3'd0, {SLV, 1'b0});
    wait_idle();
    rd(3'd5, s);
    chk("R5 data nack status", s[5:3], 3'b010);
    chk("R5 data nack flush", s[1], 1);
    chk("R5 bytes before nack", wn, 2);
    chk("R5 stop after data nack", stops, 1);
  endtask

  task automatic t_underrun();
    logic [7:0] s;
    clr_slave();
    wr(3'd1, 8'd3); wr(3'd2, 8'h44);
    wr(3'd0, {SLV, 1'b0});
    wait_idle();
    rd(3'd5, s);
    chk("R6 underrun status", s[5:3], 3'b100);
    chk("R6 delivered bytes", wn, 1);
    chk("R6 delivered value", wmem[0], 8'h44);
    chk("R6 stop", stops, 1);
  endtask

  task automatic t_chain();
    logic [7:0] s, d;
    clr_slave();
    wr(3'd1, 8'd1); wr(3'd2, 8'h77);
    wr(3'd0, {SLV, 1'b0});
    repeat (4) @(negedge clk);
    wr(3'd0, {SLV, 1'b1});
    wait_idle();
    chk("R7 starts", starts, 2);
    chk("R7 single stop", stops, 1);
    chk("R7 written", wmem[0], 8'h77);
    rd(3'd3, d);
    chk("R7 read after restart", d, 8'hC0);
    rd(3'd5, s);
    chk("R7 done", s[5:3], 3'b001);
  endtask

  task automatic t_fifo_limits();
    logic [7:0] s, d;
    clr_slave();
    for (int k = 0; k < 5; k++) wr(3'd2, 8'h10 + 8'(k));
    rd(3'd5, s);
    chk("R1 tx overflow flag", s[6], 1);
    rd(3'd3, d);
    rd(3'd5, s);
    chk("R1 rx underflow flag", s[7], 1);
    wr(3'd1, 8'd5);
    wr(3'd0, {SLV, 1'b0});
    wait_idle();
    chk("R1 only four queued", wn, 4);
    chk("R1 fourth kept", wmem[3], 8'h13);
    rd(3'd5, s);
    chk("R1 fifth dropped underrun", s[5], 1);
    wr(3'd5, 8'hC0); rd(3'd5, s);
    chk("R1 flags cleared", s[7:6], 0);
  endtask

  task automatic t_scl(input int dv);
    clr_slave();
    wr(3'd6, 8'(dv)); wr(3'd1, 8'd1); wr(3'd2, 8'hA5);
    wr(3'd0, {SLV, 1'b0});
    wait_idle();
    chk("R9 scl period", per, 4 * (dv + 1));
    chk("R9 byte intact", wmem[0], 8'hA5);
  endtask

  initial begin
    errors = 0; checks = 0; cyc = 0; finished = 0; prev_rise = -1; per = 0;
    s_lo = 0; s_act = 0; s_data = 0; s_bit = 0; s_sel = 0; s_rd = 0; s_send = 0;
    wn = 0; ridx = 0; nack_at = -1; starts = 0; stops = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write();
    t_read_full();
    t_read_modes();
    t_nack_addr();
    t_nack_data();
    t_underrun();
    t_chain();
    t_fifo_limits();
    t_scl(1);
    t_scl(3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule